// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block looks at one 16-bit instruction word and handles the instructions that change the program counter relative to itself. For the conditional and unconditional branch group, it reads the four condition flags: negative, zero, overflow and carry. From them it decides whether the branch is taken, and it computes the target as the current PC plus twice the sign-extended 8-bit offset. The current PC is the address that already points past the instruction.

The block also handles the decrement-and-loop instruction. For that instruction it produces the decremented value of the selected register and a write enable for it. It reports the register field so the surrounding datapath can select that register. It also computes a backward-only target from a 6-bit count.

Any other word raises a not-a-branch indication and leaves the PC and the registers untouched. The block is purely combinational. Instruction fetch and pipeline flushing belong to the surrounding core.

Top module: `branch_decide`

## Requirements
- R1: A word is in the branch group when bits 14..11 are 0 and either bit 15 is 1 or bits 10..8 are not 0. A word is a loop instruction when bits 15..9 equal 0111111. Every other word drives not_branch=1, taken=0, wb_en=0, wb_data=0 and target_pc=pc_in.
- R2: High byte 0x01 is the unconditional branch and is always taken, whatever the flags.
- R3: For every branch-group word, target_pc = pc_in + 2*sign-extended bits 7..0, modulo 2^16. This target is driven whether or not the branch is taken.
- R4: High byte 0x02 is taken when Z=0, and 0x03 is taken when Z=1.
- R5: The signed conditions use N XOR V. High byte 0x04 is taken when N XOR V is 0, and 0x05 when it is 1. High byte 0x06 is taken when Z OR (N XOR V) is 0, and 0x07 when it is 1.
- R6: The unsigned conditions are as follows. High byte 0x82 is taken when C OR Z is 0, and 0x83 when it is 1. High byte 0x86 is taken when C=0, and 0x87 when C=1.
- R7: The single-flag conditions are as follows. High byte 0x80 is taken when N=0, 0x81 when N=1, 0x84 when V=0, and 0x85 when V=1.
- R8: For a loop instruction, wb_en=1 and wb_data=reg_in-1 modulo 2^16, so 0 wraps to 0xFFFF. The instruction is taken only when wb_data is not 0. loop_reg equals bits 8..6 for every word.
- R9: For a loop instruction, target_pc = pc_in - 2*bits 5..0, modulo 2^16. The offset is never forward.
- R10: Branch-group words never assert wb_en and drive wb_data=0. The flags have no effect on a loop instruction or on a non-branch word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Instruction word under decision |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 16 | PC pointing past the instruction |
| reg_in | input | 16 | Value of the register named by loop_reg |
| loop_reg | output | 3 | Register field, bits 8..6 |
| taken | output | 1 | Branch is taken |
| target_pc | output | 16 | Computed target address |
| wb_data | output | 16 | Decremented register value |
| wb_en | output | 1 | Register write-back enable |
| not_branch | output | 1 | Word is not a branch or loop instruction |

## Verification
The signed and unsigned condition pairs are each swept over all sixteen flag combinations. A design that swapped XOR for OR, or that tested carry where zero was meant, would take the wrong branch in one of those rows.

The offsets +127 and -128 are applied, and PC values near both ends of the address range are used. A design that zero-extended the offset, or that forgot the doubling, would land on the wrong address.

The loop instruction is run with register values 1, 0 and 5, and with counts 0 and 63. A design that tested the value before the decrement, or that added the count, would loop once too often, or jump forward.

Words next to the encodings are applied, such as 0x0000, 0x0800 and 0x7C00. A decoder that was too loose would claim them as branches.

// File: rtl/branch_decide.sv
module branch_decide #(
  parameter int W     = 16,
  parameter int OFS_W = 8,
  parameter int CNT_W = 6,
  parameter int SEL_W = 3
) (
  input  logic [W-1:0]     instr,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic             flag_v,
  input  logic             flag_c,
  input  logic [W-1:0]     pc_in,
  input  logic [W-1:0]     reg_in,
  output logic [SEL_W-1:0] loop_reg,
  output logic             taken,
  output logic [W-1:0]     target_pc,
  output logic [W-1:0]     wb_data,
  output logic             wb_en,
  output logic             not_branch
);
  localparam int BR_PAD  = W - OFS_W - 1;
  localparam int CNT_PAD = W - CNT_W - 1;

  logic         is_br, is_loop, cond, nxv;
  logic [3:0]   sel;
  logic [W-1:0] br_ofs, loop_ofs, dec;

  assign is_br   = (instr[14:11] == 4'd0) && (instr[15] || instr[10:8] != 3'd0);
  assign is_loop = (instr[15:9] == 7'b0111111);
  assign sel     = {instr[15], instr[10:8]};
  assign nxv     = flag_n ^ flag_v;

  always_comb begin
    case (sel)
      4'h1:    cond = 1'b1;
      4'h2:    cond = !flag_z;
      4'h3:    cond = flag_z;
      4'h4:    cond = !nxv;
      4'h5:    cond = nxv;
      4'h6:    cond = !(flag_z | nxv);
      4'h7:    cond = flag_z | nxv;
      4'h8:    cond = !flag_n;
      4'h9:    cond = flag_n;
      4'hA:    cond = !(flag_c | flag_z);
      4'hB:    cond = flag_c | flag_z;
      4'hC:    cond = !flag_v;
      4'hD:    cond = flag_v;
      4'hE:    cond = !flag_c;
      4'hF:    cond = flag_c;
      default: cond = 1'b0;
    endcase
  end

  assign br_ofs   = {{BR_PAD{instr[OFS_W-1]}}, instr[OFS_W-1:0], 1'b0};
  assign loop_ofs = {{CNT_PAD{1'b0}}, instr[CNT_W-1:0], 1'b0};
  assign dec      = reg_in - {{(W-1){1'b0}}, 1'b1};

  assign loop_reg   = instr[CNT_W+SEL_W-1:CNT_W];
  assign target_pc  = is_br ? pc_in + br_ofs : (is_loop ? pc_in - loop_ofs : pc_in);
  assign taken      = is_br ? cond : (is_loop && dec != '0);
  assign wb_en      = is_loop;
  assign wb_data    = is_loop ? dec : '0;
  assign not_branch = !is_br && !is_loop;
endmodule

// File: rtl/branch_decide_chk.sv
module branch_decide_chk (
  input logic [15:0] instr,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_v,
  input logic        flag_c,
  input logic [15:0] pc_in,
  input logic [15:0] reg_in,
  input logic [2:0]  loop_reg,
  input logic        taken,
  input logic [15:0] target_pc,
  input logic [15:0] wb_data,
  input logic        wb_en,
  input logic        not_branch
);
  always_comb begin
    AST_QUIET_WHEN_NOT_BRANCH: assert (!not_branch || (!taken && !wb_en && target_pc == pc_in)); // R1
    AST_NO_BOTH: assert (!(not_branch && wb_en)); // R1
    AST_UNCOND_TAKEN: assert (instr[15:8] != 8'h01 || taken); // R2
    AST_TARGET_PARITY: assert (target_pc[0] == pc_in[0]); // R3
    AST_LOOP_ENCODING: assert (!wb_en || instr[15:9] == 7'b0111111); // R8
    AST_LOOP_ZERO_FALLS: assert (!(wb_en && wb_data == 16'd0 && taken)); // R8
    AST_LOOP_REG_FIELD: assert (loop_reg == instr[8:6]); // R8
    AST_BRANCH_NO_WB: assert (wb_en || wb_data == 16'd0); // R10
  end
endmodule

bind branch_decide branch_decide_chk u_chk (.*);

// File: tb/test_branch_decide.sv
module test_branch_decide;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [15:0] instr = 16'h0000, pc_in = 16'h1000, reg_in = 16'h0000;
  logic        flag_n = 0, flag_z = 0, flag_v = 0, flag_c = 0;
  logic [2:0]  loop_reg;
  logic        taken, wb_en, not_branch;
  logic [15:0] target_pc, wb_data;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;

  branch_decide i_branch_decide (.*);

  // Independent expectation built from the requirement text
  function automatic logic exp_cond(input logic [7:0] hi, input logic n, z, v, c);
    case (hi)
      8'h01: return 1'b1;
      8'h02: return z == 0;
      8'h03: return z == 1;
      8'h04: return (n ^ v) == 0;
      8'h05: return (n ^ v) == 1;
      8'h06: return (z | (n ^ v)) == 0;
      8'h07: return (z | (n ^ v)) == 1;
      8'h80: return n == 0;
      8'h81: return n == 1;
      8'h82: return (c | z) == 0;
      8'h83: return (c | z) == 1;
      8'h84: return v == 0;
      8'h85: return v == 1;
      8'h86: return c == 0;
      8'h87: return c == 1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [15:0] i, input logic [3:0] nzvc,
                       input logic [15:0] pc, input logic [15:0] r);
    @(negedge clk);
    instr = i; {flag_n, flag_z, flag_v, flag_c} = nzvc; pc_in = pc; reg_in = r;
    #5;
  endtask

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s instr=%h: actual %h expected %h", req, what, instr, act, exp);
    end
  endtask

  task automatic check_branch(input string req);
    logic [15:0] t;
    t = pc_in + {{7{instr[7]}}, instr[7:0], 1'b0};
    chk(req, "taken", {15'd0, taken}, {15'd0, exp_cond(instr[15:8], flag_n, flag_z, flag_v, flag_c)});
    chk("R3", "target", target_pc, t);
    chk("R10", "wb_en", {15'd0, wb_en}, 16'd0);
    chk("R10", "wb_data", wb_data, 16'd0);
    chk("R1", "not_branch", {15'd0, not_branch}, 16'd0);
  endtask

  task automatic t_reset_state;
    apply(16'h0000, 4'b0000, 16'h1000, 16'h0000);
    chk("R1", "not_branch", {15'd0, not_branch}, 16'd1);
    chk("R1", "taken", {15'd0, taken}, 16'd0);
    chk("R1", "target", target_pc, 16'h1000);
  endtask

  task automatic t_uncond;
    for (int f = 0; f < 16; f++) begin
      apply(16'h017F, f[3:0], 16'h2000, 16'h0);
      check_branch("R2");
    end
    apply(16'h0180, 4'b0000, 16'h0010, 16'h0);
    check_branch("R2");
    chk("R3", "target_wrap", target_pc, 16'hFF10);
    apply(16'h01FF, 4'b0000, 16'hFFFE, 16'h0);
    chk("R3", "target_back1", target_pc, 16'hFFFC);
  endtask

  task automatic t_group(input string req, input logic [7:0] hi);
    for (int f = 0; f < 16; f++) begin
      apply({hi, 8'h05}, f[3:0], 16'h0400, 16'h0);
      check_branch(req);
    end
  endtask

  task automatic t_loop(input logic [5:0] cnt, input logic [15:0] pc, input logic [15:0] r);
    logic [15:0] d;
    d = r - 16'd1;
    for (int f = 0; f < 16; f += 5) begin
      apply({7'b0111111, 3'd5, cnt}, f[3:0], pc, r);
      chk("R8", "wb_en", {15'd0, wb_en}, 16'd1);
      chk("R8", "wb_data", wb_data, d);
      chk("R8", "taken", {15'd0, taken}, {15'd0, d != 16'd0});
      chk("R8", "loop_reg", {13'd0, loop_reg}, 16'd5);
      chk("R9", "target", target_pc, pc - {9'd0, cnt, 1'b0});
      chk("R1", "not_branch", {15'd0, not_branch}, 16'd0);
    end
  endtask

  task automatic t_non_branch(input logic [15:0] w);
    for (int f = 0; f < 16; f += 3) begin
      apply(w, f[3:0], 16'h3456, 16'h0042);
      chk("R1", "not_branch", {15'd0, not_branch}, 16'd1);
      chk("R1", "taken", {15'd0, taken}, 16'd0);
      chk("R10", "wb_en", {15'd0, wb_en}, 16'd0);
      chk("R1", "wb_data", wb_data, 16'd0);
      chk("R1", "target", target_pc, 16'h3456);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_uncond();
    t_group("R4", 8'h02); t_group("R4", 8'h03);
    t_group("R5", 8'h04); t_group("R5", 8'h05);
    t_group("R5", 8'h06); t_group("R5", 8'h07);
    t_group("R6", 8'h82); t_group("R6", 8'h83);
    t_group("R6", 8'h86); t_group("R6", 8'h87);
    t_group("R7", 8'h80); t_group("R7", 8'h81);
    t_group("R7", 8'h84); t_group("R7", 8'h85);
    t_loop(6'd3, 16'h0100, 16'h0001);
    t_loop(6'd63, 16'h0040, 16'h0000);
    t_loop(6'd0, 16'h8000, 16'h0005);
    t_loop(6'd63, 16'hFFFE, 16'h8000);
    t_non_branch(16'h0000);
    t_non_branch(16'h00FF);
    t_non_branch(16'h0800);
    t_non_branch(16'h7C00);
    t_non_branch(16'h8800);
    t_non_branch(16'hFFFF);
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
    end
  end

  initial begin
    wait (done);
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule